// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transceiver

This block is a full-duplex asynchronous serial port. The format of each character is chosen at run time. One configuration sets the character length, whether a parity bit is present, the parity sense and the number of stop bits. The same configuration serves both directions. The block does not divide the baud rate itself: it is driven by a single-cycle tick that a baud-rate generator outside the block provides at sixteen times the bit rate.

On the host side, a character is handed to the transmitter with a one-cycle start strobe while the busy flag is low. The receiver presents each completed character with a valid flag, which stays set until the host pulses a read strobe. Three error flags describe the character just received: parity, framing and overrun. A fourth flag is the OR of those three. On the line side there is one serial output, which idles high, and one serial input. The input passes through a synchronizer before it is used.

Top module: `uart_xcvr`

## Requirements
- R1: After reset `txd` is 1 and `tx_busy` is 0. A `tx_start` pulse seen while `tx_busy` is 0 is accepted at that clock edge. At the same edge `txd` drives the start bit (0) and `tx_busy` goes to 1. `txd` is 1 whenever `tx_busy` is 0.
- R2: Each transmitted bit lasts exactly 16 ticks. The frame is sent in this order: one start bit, the data bits with the least significant bit first, the parity bit if enabled, then the stop bits (1). `tx_busy` falls at the edge that ends the last stop bit.
- R3: `cfg_len` selects the character length for both directions. The encoding is 00 = 7 bits, 01 = 8 bits, 10 = 9 bits and 11 = 8 bits.
- R4: When `cfg_par_en` is 1, one parity bit follows the last data bit. With `cfg_par_odd` = 0 the count of ones across the data and parity bits is even. With `cfg_par_odd` = 1 that count is odd. When `cfg_par_en` is 0 no parity bit is sent.
- R5: `cfg_stop2` = 0 gives one stop bit and `cfg_stop2` = 1 gives two.
- R6: A `tx_start` pulse that arrives while `tx_busy` is 1 has no effect. The frame in progress is sent unchanged.
- R7: The receiver starts a frame on a high-to-low change of the synchronized input. It confirms the start bit at the 8th tick. If the line is high again at that point, the frame is abandoned and no character is produced.
- R8: Received data is assembled with the least significant bit first, and unused upper bits of `rx_data` read 0. `rx_valid` sets when the last stop bit is sampled and clears on `rx_read`.
- R9: `rx_err_parity` is 1 for a received character whose parity bit does not match the configured sense. It is always 0 when parity is disabled.
- R10: `rx_err_frame` is 1 for a received character in which any stop bit was sampled low.
- R11: `rx_err_overrun` is 1 for a received character that completed while `rx_valid` was still set and not being read. The new character replaces the old one in `rx_data`.
- R12: All three error flags are reloaded each time a character completes. `rx_err_sum` is 1 exactly when any of them is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | One-cycle pulse at 16x the bit rate |
| cfg_len | input | 2 | Character length select |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | Parity sense, 1 = odd |
| cfg_stop2 | input | 1 | Two stop bits when 1 |
| tx_data | input | 9 | Character to send |
| tx_start | input | 1 | Send strobe |
| tx_busy | output | 1 | Transmitter occupied |
| txd | output | 1 | Serial output |
| rxd | input | 1 | Serial input (asynchronous) |
| rx_read | input | 1 | Host consumes received character |
| rx_data | output | 9 | Received character |
| rx_valid | output | 1 | Character waiting |
| rx_err_parity | output | 1 | Parity mismatch |
| rx_err_frame | output | 1 | Stop bit sampled low |
| rx_err_overrun | output | 1 | Previous character lost |
| rx_err_sum | output | 1 | Any error |

## Verification
The transmitter is tried with all three lengths plus the spare length code. It runs with parity off, even and odd, and with one and two stop bits. Its line and busy flag are compared every cycle against a bit-queue model, so a swapped bit order, a wrong parity sense or a missing stop bit each shows up at a distinct tick. The receiver is fed frames with a corrupted parity bit, with a low first stop bit and with a low second stop bit. It also gets two back-to-back unread frames and a short low glitch. These separate the parity, framing and overrun flags from one another and from false-start rejection. A loopback frame in 9-bit, two-stop format shows that both directions agree on the format.

// File: rtl/uart_xcvr_pkg.sv
package uart_xcvr_pkg;

  localparam int CHAR_MAX = 9;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_START,
    PH_DATA,
    PH_PAR,
    PH_STOP
  } phase_e;

  // Number of data bits for a length code (11 maps to 8)
  function automatic logic [3:0] char_bits(input logic [1:0] len);
    case (len)
      2'b00:   return 4'd7;
      2'b10:   return 4'd9;
      default: return 4'd8;
    endcase
  endfunction

  // Parity bit value that makes the total number of ones even (odd = 0) or odd (odd = 1)
  function automatic logic frame_parity(input logic [CHAR_MAX-1:0] d,
                                        input logic [3:0] nbits,
                                        input logic odd);
    logic p;
    p = odd;
    for (int i = 0; i < CHAR_MAX; i++) begin
      if (4'(i) < nbits) p = p ^ d[i];
    end
    return p;
  endfunction

endpackage

// File: rtl/uart_line_sync.sv
module uart_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/uart_tx_engine.sv
module uart_tx_engine
  import uart_xcvr_pkg::*;
#(
  parameter int OVERSAMPLE = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic                start,
  input  logic [CHAR_MAX-1:0] data,
  input  logic [1:0]          cfg_len,
  input  logic                par_en,
  input  logic                par_odd,
  input  logic                stop2,
  output logic                txd,
  output logic                busy
);
  localparam int CNT_W = $clog2(OVERSAMPLE);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OVERSAMPLE - 1);

  phase_e              state;
  logic [CNT_W-1:0]    cnt;
  logic [3:0]          idx;
  logic [3:0]          last_idx;
  logic [CHAR_MAX-1:0] data_q;
  logic                pen_q, par_q, stop2_q, stop_idx;

  // named events for the checks below
  logic       accept_w, bit_end_w, data_last_w;
  logic [3:0] idx_nxt;

  assign accept_w    = start && (state == PH_IDLE);
  assign bit_end_w   = tick && (state != PH_IDLE) && (cnt == CNT_LAST);
  assign data_last_w = (idx == last_idx);
  assign idx_nxt     = idx + 4'd1;
  assign busy        = (state != PH_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= PH_IDLE;
      txd      <= 1'b1;
      cnt      <= '0;
      idx      <= '0;
      last_idx <= '0;
      data_q   <= '0;
      pen_q    <= 1'b0;
      par_q    <= 1'b0;
      stop2_q  <= 1'b0;
      stop_idx <= 1'b0;
    end else if (accept_w) begin
      state    <= PH_START;
      txd      <= 1'b0;
      cnt      <= '0;
      idx      <= '0;
      data_q   <= data;
      last_idx <= char_bits(cfg_len) - 4'd1;
      pen_q    <= par_en;
      par_q    <= frame_parity(data, char_bits(cfg_len), par_odd);
      stop2_q  <= stop2;
      stop_idx <= 1'b0;
    end else if (tick && state != PH_IDLE) begin
      if (!bit_end_w) begin
        cnt <= cnt + 1'b1;
      end else begin
        cnt <= '0;
        case (state)
          PH_START: begin
            state <= PH_DATA;
            idx   <= '0;
            txd   <= data_q[0];
          end
          PH_DATA: begin
            if (data_last_w) begin
              if (pen_q) begin
                state <= PH_PAR;
                txd   <= par_q;
              end else begin
                state <= PH_STOP;
                txd   <= 1'b1;
              end
            end else begin
              idx <= idx_nxt;
              txd <= data_q[idx_nxt];
            end
          end
          PH_PAR: begin
            state <= PH_STOP;
            txd   <= 1'b1;
          end
          PH_STOP: begin
            txd <= 1'b1;
            if (stop2_q && !stop_idx) stop_idx <= 1'b1;
            else                      state    <= PH_IDLE;
          end
          default: state <= PH_IDLE;
        endcase
      end
    end
  end

  assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd);
  assert_accept_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    accept_w |=> (busy && !txd));
  assert_ignore_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(data_q));
  assert_parity_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PH_PAR) |-> pen_q);
  assert_stop_line_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PH_STOP) |-> txd);
endmodule

// File: rtl/uart_rx_engine.sv
module uart_rx_engine
  import uart_xcvr_pkg::*;
#(
  parameter int OVERSAMPLE = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic                rx_s,
  input  logic [1:0]          cfg_len,
  input  logic                par_en,
  input  logic                par_odd,
  input  logic                stop2,
  input  logic                rd,
  output logic [CHAR_MAX-1:0] rx_data,
  output logic                rx_valid,
  output logic                err_par,
  output logic                err_frame,
  output logic                err_ovr
);
  localparam int CNT_W = $clog2(OVERSAMPLE);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OVERSAMPLE - 1);
  localparam logic [CNT_W-1:0] CNT_MID  = CNT_W'(OVERSAMPLE / 2 - 1);

  phase_e              state;
  logic [CNT_W-1:0]    cnt;
  logic [3:0]          idx;
  logic [3:0]          nbits_q;
  logic [CHAR_MAX-1:0] data_q;
  logic                pen_q, odd_q, stop2_q, stop_idx;
  logic                ferr_q, par_rx, prev_s;

  // named events
  logic fall_w, mid_w, sample_w, done_w, par_bad_w, frame_bad_w, false_start_w;

  assign fall_w        = tick && (state == PH_IDLE) && prev_s && !rx_s;
  assign mid_w         = tick && (state == PH_START) && (cnt == CNT_MID);
  assign false_start_w = mid_w && rx_s;
  assign sample_w      = tick && (state inside {PH_DATA, PH_PAR, PH_STOP}) && (cnt == CNT_LAST);
  assign done_w        = sample_w && (state == PH_STOP) && !(stop2_q && !stop_idx);
  assign par_bad_w     = pen_q && (par_rx != frame_parity(data_q, nbits_q, odd_q));
  assign frame_bad_w   = ferr_q || !rx_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= PH_IDLE;
      cnt      <= '0;
      idx      <= '0;
      nbits_q  <= 4'd8;
      data_q   <= '0;
      pen_q    <= 1'b0;
      odd_q    <= 1'b0;
      stop2_q  <= 1'b0;
      stop_idx <= 1'b0;
      ferr_q   <= 1'b0;
      par_rx   <= 1'b0;
      prev_s   <= 1'b1;
    end else if (tick) begin
      case (state)
        PH_IDLE: begin
          prev_s <= rx_s;
          if (fall_w) begin
            state    <= PH_START;
            cnt      <= '0;
            nbits_q  <= char_bits(cfg_len);
            pen_q    <= par_en;
            odd_q    <= par_odd;
            stop2_q  <= stop2;
            data_q   <= '0;
            ferr_q   <= 1'b0;
            stop_idx <= 1'b0;
          end
        end
        PH_START: begin
          if (!mid_w) begin
            cnt <= cnt + 1'b1;
          end else if (false_start_w) begin
            state  <= PH_IDLE;
            prev_s <= 1'b1;
          end else begin
            state <= PH_DATA;
            cnt   <= '0;
            idx   <= '0;
          end
        end
        PH_DATA: begin
          if (!sample_w) begin
            cnt <= cnt + 1'b1;
          end else begin
            cnt         <= '0;
            data_q[idx] <= rx_s;
            if (idx == nbits_q - 4'd1) state <= pen_q ? PH_PAR : PH_STOP;
            else                       idx   <= idx + 4'd1;
          end
        end
        PH_PAR: begin
          if (!sample_w) begin
            cnt <= cnt + 1'b1;
          end else begin
            cnt    <= '0;
            par_rx <= rx_s;
            state  <= PH_STOP;
          end
        end
        PH_STOP: begin
          if (!sample_w) begin
            cnt <= cnt + 1'b1;
          end else begin
            cnt <= '0;
            if (!done_w) begin
              stop_idx <= 1'b1;
              ferr_q   <= frame_bad_w;
            end else begin
              state  <= PH_IDLE;
              prev_s <= rx_s;
            end
          end
        end
        default: state <= PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data   <= '0;
      rx_valid  <= 1'b0;
      err_par   <= 1'b0;
      err_frame <= 1'b0;
      err_ovr   <= 1'b0;
    end else if (done_w) begin
      rx_data   <= data_q;
      rx_valid  <= 1'b1;
      err_par   <= par_bad_w;
      err_frame <= frame_bad_w;
      err_ovr   <= rx_valid && !rd;
    end else if (rd) begin
      rx_valid  <= 1'b0;
    end
  end

  assert_valid_on_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_w |=> rx_valid);
  assert_upper_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_w && nbits_q == 4'd7) |=> (rx_data[8:7] == 2'b00));
  assert_no_parity_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done_w && !pen_q) |=> !err_par);
  assert_overrun_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (done_w && rx_valid && !rd) |=> err_ovr);
  assert_false_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    false_start_w |=> (state == PH_IDLE));
  assert_frame_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done_w && !rx_s) |=> err_frame);
endmodule

// File: rtl/uart_xcvr.sv
module uart_xcvr
  import uart_xcvr_pkg::*;
#(
  parameter int OVERSAMPLE  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick16,
  input  logic [1:0]          cfg_len,
  input  logic                cfg_par_en,
  input  logic                cfg_par_odd,
  input  logic                cfg_stop2,
  input  logic [CHAR_MAX-1:0] tx_data,
  input  logic                tx_start,
  output logic                tx_busy,
  output logic                txd,
  input  logic                rxd,
  input  logic                rx_read,
  output logic [CHAR_MAX-1:0] rx_data,
  output logic                rx_valid,
  output logic                rx_err_parity,
  output logic                rx_err_frame,
  output logic                rx_err_overrun,
  output logic                rx_err_sum
);
  logic rx_s;

  uart_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(rxd), .dout(rx_s)
  );

  uart_tx_engine #(.OVERSAMPLE(OVERSAMPLE)) u_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick16), .start(tx_start), .data(tx_data),
    .cfg_len(cfg_len), .par_en(cfg_par_en), .par_odd(cfg_par_odd), .stop2(cfg_stop2),
    .txd(txd), .busy(tx_busy)
  );

  uart_rx_engine #(.OVERSAMPLE(OVERSAMPLE)) u_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick16), .rx_s(rx_s),
    .cfg_len(cfg_len), .par_en(cfg_par_en), .par_odd(cfg_par_odd), .stop2(cfg_stop2),
    .rd(rx_read), .rx_data(rx_data), .rx_valid(rx_valid),
    .err_par(rx_err_parity), .err_frame(rx_err_frame), .err_ovr(rx_err_overrun)
  );

  assign rx_err_sum = rx_err_parity | rx_err_frame | rx_err_overrun;
endmodule

// File: tb/uart_xcvr_tb.sv
module uart_xcvr_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick16 = 1'b0;
  logic [1:0] c_len = 2'b01;
  logic       c_pe = 1'b0, c_po = 1'b0, c_s2 = 1'b0;
  logic [8:0] tx_data = '0;
  logic       tx_start = 1'b0;
  logic       tx_busy, txd;
  logic       rx_drv = 1'b1, loop = 1'b0, rx_read = 1'b0;
  logic       rxd;
  logic [8:0] rx_data;
  logic       rx_valid, e_par, e_frm, e_ovr, e_sum;

  int checks = 0;
  int errors = 0;

  assign rxd = loop ? txd : rx_drv;

  always #5 clk = ~clk;

  uart_xcvr u_dut (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .cfg_len(c_len),
    .cfg_par_en(c_pe), .cfg_par_odd(c_po), .cfg_stop2(c_s2),
    .tx_data(tx_data), .tx_start(tx_start), .tx_busy(tx_busy), .txd(txd),
    .rxd(rxd), .rx_read(rx_read), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_err_parity(e_par), .rx_err_frame(e_frm), .rx_err_overrun(e_ovr),
    .rx_err_sum(e_sum)
  );

  // tick every 4 clocks
  int tdiv = 0;
  always @(negedge clk) begin
    tdiv = (tdiv + 1) % 4;
    tick16 <= (tdiv == 3);
  end

  function automatic int len_of(input logic [1:0] l);
    if (l == 2'b00) return 7;
    if (l == 2'b10) return 9;
    return 8;
  endfunction

  function automatic bit par_of(input logic [8:0] d, input int n, input bit odd);
    int ones = 0;
    for (int i = 0; i < n; i++) ones += int'(d[i]);
    return bit'(ones % 2) ^ odd;
  endfunction

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // transmit reference model: a queue of line levels, 16 ticks each
  bit   m_q[$];
  bit   m_busy = 1'b0, m_line = 1'b1;
  int   m_cnt = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 1'b0; m_line = 1'b1; m_cnt = 0; m_q.delete();
    end else if (!m_busy && tx_start) begin
      int n;
      n = len_of(c_len);
      m_q.delete();
      for (int i = 0; i < n; i++) m_q.push_back(tx_data[i]);
      if (c_pe) m_q.push_back(par_of(tx_data, n, c_po));
      m_q.push_back(1'b1);
      if (c_s2) m_q.push_back(1'b1);
      m_line = 1'b0; m_busy = 1'b1; m_cnt = 0;
    end else if (m_busy && tick16) begin
      m_cnt++;
      if (m_cnt == 16) begin
        m_cnt = 0;
        if (m_q.size() == 0) begin m_busy = 1'b0; m_line = 1'b1; end
        else m_line = m_q.pop_front();
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(txd == m_line, "R2 R3 R4 R5 txd", int'(txd), int'(m_line));
      chk(tx_busy == m_busy, "R1 R6 tx_busy", int'(tx_busy), int'(m_busy));
    end
  end

  task automatic wait_ticks(input int n);
    int k = 0;
    while (k < n) begin
      @(posedge clk);
      if (tick16) k++;
    end
    @(negedge clk);
  endtask

  task automatic send_tx(input logic [8:0] d, input bit poke_busy);
    @(negedge clk);
    while (tx_busy) @(negedge clk);
    tx_data = d; tx_start = 1'b1;
    @(negedge clk);
    tx_start = 1'b0;
    if (poke_busy) begin
      wait_ticks(40);
      tx_data = ~d; tx_start = 1'b1;   // R6 ignored start
      @(negedge clk);
      tx_start = 1'b0;
    end
    while (tx_busy) @(negedge clk);
    wait_ticks(3);
  endtask

  // bad_stop: 0 none, 1 first stop low, 2 second stop low
  task automatic drive_frame(input logic [8:0] d, input bit bad_par, input int bad_stop);
    int n;
    n = len_of(c_len);
    rx_drv = 1'b0; wait_ticks(16);
    for (int i = 0; i < n; i++) begin rx_drv = d[i]; wait_ticks(16); end
    if (c_pe) begin rx_drv = par_of(d, n, c_po) ^ bad_par; wait_ticks(16); end
    rx_drv = (bad_stop != 1); wait_ticks(16);
    if (c_s2) begin rx_drv = (bad_stop != 2); wait_ticks(16); end
    rx_drv = 1'b1; wait_ticks(4);
  endtask

  task automatic check_rx(input logic [8:0] d, input bit ep, input bit ef, input bit eo);
    logic [8:0] m;
    m = d & ((9'h1 << len_of(c_len)) - 9'h1);
    chk(rx_valid == 1'b1, "R8 rx_valid", int'(rx_valid), 1);
    chk(rx_data == m, "R8 R3 rx_data", int'(rx_data), int'(m));
    chk(e_par == ep, "R9 parity flag", int'(e_par), int'(ep));
    chk(e_frm == ef, "R10 frame flag", int'(e_frm), int'(ef));
    chk(e_ovr == eo, "R11 overrun flag", int'(e_ovr), int'(eo));
    chk(e_sum == (ep | ef | eo), "R12 sum flag", int'(e_sum), int'(ep | ef | eo));
  endtask

  task automatic read_rx();
    rx_read = 1'b1;
    @(negedge clk);
    rx_read = 1'b0;
    @(negedge clk);
    chk(rx_valid == 1'b0, "R8 valid cleared", int'(rx_valid), 0);
  endtask

  task automatic set_cfg(input logic [1:0] l, input bit pe, input bit po, input bit s2);
    c_len = l; c_pe = pe; c_po = po; c_s2 = s2;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(txd == 1'b1, "R1 reset txd", int'(txd), 1);
    chk(tx_busy == 1'b0, "R1 reset busy", int'(tx_busy), 0);
    chk(rx_valid == 1'b0, "R8 reset valid", int'(rx_valid), 0);
    chk(e_sum == 1'b0, "R12 reset sum", int'(e_sum), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // transmit formats (R2 R3 R4 R5 R6)
    set_cfg(2'b01, 0, 0, 0); send_tx(9'h0A5, 0);
    set_cfg(2'b00, 1, 0, 0); send_tx(9'h055, 0);
    set_cfg(2'b10, 1, 1, 1); send_tx(9'h1C3, 0);
    set_cfg(2'b01, 1, 0, 1); send_tx(9'h03C, 1);
    set_cfg(2'b11, 1, 1, 0); send_tx(9'h1F0, 0);

    // receive formats
    set_cfg(2'b01, 0, 0, 0); drive_frame(9'h0B4, 0, 0); check_rx(9'h0B4, 0, 0, 0); read_rx();
    set_cfg(2'b00, 1, 0, 0); drive_frame(9'h1FF, 0, 0); check_rx(9'h1FF, 0, 0, 0); read_rx(); // R3 R8 upper zero
    set_cfg(2'b10, 1, 1, 1); drive_frame(9'h16B, 0, 0); check_rx(9'h16B, 0, 0, 0); read_rx();
    set_cfg(2'b01, 1, 1, 0); drive_frame(9'h0C3, 1, 0); check_rx(9'h0C3, 1, 0, 0); read_rx(); // R9
    set_cfg(2'b01, 1, 0, 0); drive_frame(9'h011, 1, 0); check_rx(9'h011, 1, 0, 0); read_rx(); // R9
    set_cfg(2'b01, 0, 0, 0); drive_frame(9'h07E, 0, 1); check_rx(9'h07E, 0, 1, 0); read_rx(); // R10
    set_cfg(2'b01, 0, 0, 1); drive_frame(9'h081, 0, 2); check_rx(9'h081, 0, 1, 0); read_rx(); // R10 second stop
    set_cfg(2'b00, 0, 0, 0);
    drive_frame(9'h012, 0, 0);
    drive_frame(9'h06D, 0, 0); check_rx(9'h06D, 0, 0, 1); read_rx();                         // R11
    drive_frame(9'h033, 0, 0); check_rx(9'h033, 0, 0, 0); read_rx();                         // R12 reload

    // R7 false start
    rx_drv = 1'b0; wait_ticks(3); rx_drv = 1'b1; wait_ticks(40);
    chk(rx_valid == 1'b0, "R7 glitch ignored", int'(rx_valid), 0);
    set_cfg(2'b01, 1, 0, 0); drive_frame(9'h0A7, 0, 0); check_rx(9'h0A7, 0, 0, 0); read_rx(); // R7 recovery

    // loopback, 9 bits even parity two stops
    set_cfg(2'b10, 1, 0, 1);
    loop = 1'b1;
    send_tx(9'h12D, 0);
    check_rx(9'h12D, 0, 0, 0);
    read_rx();
    loop = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule